// File: doc/BRIEF.md
# Cross-Clock Video Line Buffer

This block moves a stream of 8-bit grayscale pixels from a fast producer clock into a slower display clock. On the fast side, a pattern source steps through a raster one position at a time. It draws a single white column and a single white row on black. Each pixel goes into a dual-clock buffer, and the source stalls whenever the buffer is full. The fast and slow clocks have no defined relationship.

On the slow side, an external display timing generator asserts a pixel-request strobe for every active pixel. Each strobe pops one stored pixel, and that byte appears on the red, green and blue outputs one display clock later. A one-bit start-of-frame mark is stored with each pixel so that the display can line up with the top-left corner of the raster. Full and empty are found by sending Gray-coded pointers across the clock boundary through two-flop synchronisers. A request made while the buffer is empty yields black and sets a sticky underflow flag.

Top module: `xlb_line_buf`

## Requirements
- R1: While either reset is low, the state it covers is cleared: the pointers, the raster position, the output-valid stage and the underflow flag. Outputs read zero, sof_o is 0 and underflow_o is 0 after reset.
- R2: red_o, grn_o and blu_o always carry the same byte.
- R3: The writer stores a pixel and advances its raster position only when the buffer is not full. The popped pixels are therefore exactly the raster sequence, with none lost, repeated or skipped, and the stored count never exceeds 2^ADDR_W (default 2048 words).
- R4: The raster counts the horizontal index from 0 to H_TOTAL-1 and the line index from 0 to V_TOTAL-1, both wrapping, with defaults of 1056 and 626. The horizontal index runs fastest.
- R5: A pixel is 8'hFF when its horizontal index equals H_MARK or its line index equals V_MARK, and 8'h00 otherwise. The defaults are 600 and 300.
- R6: When pix_req_i is high at a rising rclk_i edge and the buffer is not empty, the next stored pixel is popped. It appears on the colour outputs directly after that edge and stays until the next edge.
- R7: When pix_req_i is low at an edge, nothing is popped, and the colour outputs and sof_o are zero after that edge.
- R8: When pix_req_i is high at an edge and the buffer is empty, nothing is popped and the outputs are zero after that edge. underflow_o then goes to 1 and stays at 1 until rrst_ni is asserted.
- R9: sof_o is 1 together with the pixel at raster position (0,0), and 0 with every other pixel.
- R10: Each pointer crosses the clock boundary in Gray code through two synchronising flops, so each pointer's Gray value changes by at most one bit per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Fast producer clock |
| wrst_ni | input | 1 | Producer-side active-low reset, released synchronously to wclk_i |
| rclk_i | input | 1 | Display clock |
| rrst_ni | input | 1 | Display-side active-low reset, released synchronously to rclk_i |
| pix_req_i | input | 1 | Pixel request from the display timing generator |
| red_o | output | 8 | Red channel |
| grn_o | output | 8 | Green channel |
| blu_o | output | 8 | Blue channel |
| sof_o | output | 1 | Start-of-frame mark accompanying pixel (0,0) |
| underflow_o | output | 1 | Sticky flag: a request found the buffer empty |

## Verification
The bench uses a small buffer and a small raster, so the writer spends most of its time blocked on a full buffer. A full-flag error shows up as a skipped or overwritten pixel, which breaks the popped sequence against the raster model. Requests are random gaps mixed with long bursts. A design that pops on idle cycles, or that shows a stale byte during blanking, drifts away from the model or shows non-zero colour. A directed phase holds the writer in reset and issues requests, so every request meets an empty buffer. A wrong empty compare then returns data, and a non-sticky flag then drops to 0. The first pixel after reset and each frame wrap check the start mark, and the many white-row and white-column crossings check the pattern comparison.

// File: rtl/xlb_pkg.sv
package xlb_pkg;
  localparam int PIX_W = 8;
  typedef logic [PIX_W-1:0] pix_t;
  typedef struct packed {
    logic sof;
    pix_t pix;
  } cell_t;
  localparam int CELL_W = $bits(cell_t);
endpackage

// File: rtl/xlb_sync2.sv
module xlb_sync2 #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/xlb_dpram.sv
module xlb_dpram #(
  parameter int ADDR_W = 11,
  parameter int W      = 9
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              rclk_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [W-1:0]      rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i) begin
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/xlb_pattern_wr.sv
module xlb_pattern_wr
  import xlb_pkg::*;
#(
  parameter int H_TOTAL = 1056,
  parameter int V_TOTAL = 626,
  parameter int H_MARK  = 600,
  parameter int V_MARK  = 300
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  adv_i,
  output cell_t cell_o
);
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic          h_last, v_last, on_mark;

  assign h_last = (h_q == HW'(H_TOTAL - 1));
  assign v_last = (v_q == VW'(V_TOTAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (adv_i) begin
      if (h_last) begin
        h_q <= '0;
        v_q <= v_last ? '0 : v_q + VW'(1);
      end else begin
        h_q <= h_q + HW'(1);
      end
    end
  end

  assign on_mark    = (h_q == HW'(H_MARK)) || (v_q == VW'(V_MARK));
  assign cell_o.pix = on_mark ? '1 : '0;
  assign cell_o.sof = (h_q == '0) && (v_q == '0);
endmodule

// File: rtl/xlb_line_buf.sv
module xlb_line_buf
  import xlb_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int H_TOTAL = 1056,
  parameter int V_TOTAL = 626,
  parameter int H_MARK  = 600,
  parameter int V_MARK  = 300
) (
  input  logic             wclk_i,
  input  logic             wrst_ni,
  input  logic             rclk_i,
  input  logic             rrst_ni,
  input  logic             pix_req_i,
  output logic [PIX_W-1:0] red_o,
  output logic [PIX_W-1:0] grn_o,
  output logic [PIX_W-1:0] blu_o,
  output logic             sof_o,
  output logic             underflow_o
);
  localparam int PTR_W = ADDR_W + 1;

  // write domain
  logic [PTR_W-1:0] wptr_bin, wptr_gray, rptr_gray_w, wptr_nxt;
  logic             wfull, wr_en;
  cell_t            wcell;

  assign wfull    = (wptr_gray == {~rptr_gray_w[PTR_W-1:PTR_W-2], rptr_gray_w[PTR_W-3:0]});
  assign wr_en    = !wfull;
  assign wptr_nxt = wptr_bin + PTR_W'(1);

  always_ff @(posedge wclk_i or negedge wrst_ni) begin
    if (!wrst_ni) begin
      wptr_bin  <= '0;
      wptr_gray <= '0;
    end else if (wr_en) begin
      wptr_bin  <= wptr_nxt;
      wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
    end
  end

  xlb_pattern_wr #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .H_MARK(H_MARK), .V_MARK(V_MARK)
  ) u_pat (
    .clk_i (wclk_i),
    .rst_ni(wrst_ni),
    .adv_i (wr_en),
    .cell_o(wcell)
  );

  // read domain
  logic [PTR_W-1:0] rptr_bin, rptr_gray, wptr_gray_r, rptr_nxt;
  logic             rempty, pop, vld_q, uflow_q;
  logic [CELL_W-1:0] rdata;
  cell_t            rcell;

  assign rempty   = (rptr_gray == wptr_gray_r);
  assign pop      = pix_req_i && !rempty;
  assign rptr_nxt = rptr_bin + PTR_W'(1);

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni) begin
      rptr_bin  <= '0;
      rptr_gray <= '0;
      vld_q     <= 1'b0;
      uflow_q   <= 1'b0;
    end else begin
      vld_q <= pop;
      if (pix_req_i && rempty) uflow_q <= 1'b1;
      if (pop) begin
        rptr_bin  <= rptr_nxt;
        rptr_gray <= rptr_nxt ^ (rptr_nxt >> 1);
      end
    end
  end

  xlb_sync2 #(.W(PTR_W)) u_sync_r2w (
    .clk_i (wclk_i),
    .rst_ni(wrst_ni),
    .d_i   (rptr_gray),
    .q_o   (rptr_gray_w)
  );

  xlb_sync2 #(.W(PTR_W)) u_sync_w2r (
    .clk_i (rclk_i),
    .rst_ni(rrst_ni),
    .d_i   (wptr_gray),
    .q_o   (wptr_gray_r)
  );

  xlb_dpram #(.ADDR_W(ADDR_W), .W(CELL_W)) u_mem (
    .wclk_i (wclk_i),
    .we_i   (wr_en),
    .waddr_i(wptr_bin[ADDR_W-1:0]),
    .wdata_i(wcell),
    .rclk_i (rclk_i),
    .re_i   (pop),
    .raddr_i(rptr_bin[ADDR_W-1:0]),
    .rdata_o(rdata)
  );

  assign rcell       = cell_t'(rdata);
  assign red_o       = vld_q ? rcell.pix : '0;
  assign grn_o       = red_o;
  assign blu_o       = red_o;
  assign sof_o       = vld_q && rcell.sof;
  assign underflow_o = uflow_q;
endmodule

// File: rtl/xlb_line_buf_chk.sv
module xlb_line_buf_chk #(
  parameter int ADDR_W = 11
) (
  input logic              wclk_i,
  input logic              wrst_ni,
  input logic              rclk_i,
  input logic              rrst_ni,
  input logic              pix_req_i,
  input logic [7:0]        red_o,
  input logic [7:0]        grn_o,
  input logic [7:0]        blu_o,
  input logic              sof_o,
  input logic              underflow_o,
  input logic [ADDR_W:0]   wptr_bin,
  input logic [ADDR_W:0]   wptr_gray,
  input logic [ADDR_W:0]   rptr_gray_w,
  input logic [ADDR_W:0]   rptr_gray
);
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH = PTR_W'(1 << ADDR_W);

  function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] occ_w;
  assign occ_w = wptr_bin - g2b(rptr_gray_w);

  p_no_overflow_r3: assert property (@(posedge wclk_i) disable iff (!wrst_ni || !rrst_ni)
    occ_w <= DEPTH);

  p_rgb_same_r2: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (red_o == grn_o) && (grn_o == blu_o));

  p_blank_r7: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    !pix_req_i |=> (red_o == 8'h00) && !sof_o);

  p_uflow_sticky_r8: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    underflow_o |=> underflow_o);

  p_uflow_cause_r8: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    $rose(underflow_o) |-> $past(pix_req_i));

  p_wgray_step_r10: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

  p_rgray_step_r10: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    $countones(rptr_gray ^ $past(rptr_gray)) <= 1);
endmodule

bind xlb_line_buf xlb_line_buf_chk #(.ADDR_W(ADDR_W)) u_chk (
  .wclk_i     (wclk_i),
  .wrst_ni    (wrst_ni),
  .rclk_i     (rclk_i),
  .rrst_ni    (rrst_ni),
  .pix_req_i  (pix_req_i),
  .red_o      (red_o),
  .grn_o      (grn_o),
  .blu_o      (blu_o),
  .sof_o      (sof_o),
  .underflow_o(underflow_o),
  .wptr_bin   (wptr_bin),
  .wptr_gray  (wptr_gray),
  .rptr_gray_w(rptr_gray_w),
  .rptr_gray  (rptr_gray)
);

// File: tb/xlb_line_buf_bench.sv
`timescale 1ns/1ps
module xlb_line_buf_bench;
  localparam int ADDR_W = 5;
  localparam int HT = 40, VT = 12, HM = 25, VM = 7;

  logic wclk = 0, rclk = 0;
  logic wrst_n = 0, rrst_n = 0, req = 0;
  logic [7:0] red, grn, blu;
  logic sof, uflow;

  int n_chk = 0, n_bad = 0;
  int pix_n = 0;
  logic req_prev = 0;

  always #3.5 wclk = ~wclk;
  always #10  rclk = ~rclk;

  xlb_line_buf #(.ADDR_W(ADDR_W), .H_TOTAL(HT), .V_TOTAL(VT), .H_MARK(HM), .V_MARK(VM))
  u_xlb_line_buf (
    .wclk_i(wclk), .wrst_ni(wrst_n), .rclk_i(rclk), .rrst_ni(rrst_n),
    .pix_req_i(req), .red_o(red), .grn_o(grn), .blu_o(blu),
    .sof_o(sof), .underflow_o(uflow)
  );

  function automatic logic [7:0] exp_pix(input int n);
    int h = n % HT;
    int v = (n / HT) % VT;
    return (h == HM || v == VM) ? 8'hFF : 8'h00;
  endfunction

  function automatic logic exp_sof(input int n);
    return (n % (HT * VT)) == 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // check outputs for the request sampled at the last edge, then drive the next one
  task automatic step(input logic nreq);
    @(negedge rclk);
    chk(red == grn && grn == blu, "R2 rgb equal", {red, grn, blu}, {red, red, red});
    if (req_prev) begin
      chk(red == exp_pix(pix_n), "R3 R4 R5 R6 pixel", red, exp_pix(pix_n));
      chk(sof == exp_sof(pix_n), "R9 sof", sof, exp_sof(pix_n));
      pix_n++;
    end else begin
      chk(red == 8'h00 && sof == 1'b0, "R7 blank", {sof, red}, 0);
    end
    chk(uflow == 1'b0, "R8 no underflow", uflow, 0);
    req = nreq;
    req_prev = nreq;
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20241));
    repeat (3) @(negedge rclk);
    chk(red == 0 && sof == 0, "R1 reset outputs", {sof, red}, 0);
    chk(uflow == 0, "R1 reset underflow", uflow, 0);

    // writer held in reset: every request meets an empty buffer
    rrst_n = 1;
    @(negedge rclk); req = 1;
    @(negedge rclk);
    chk(red == 0 && sof == 0, "R8 empty gives zero", red, 0);
    chk(uflow == 1, "R8 underflow set", uflow, 1);
    req = 0;
    repeat (5) @(negedge rclk);
    chk(uflow == 1, "R8 underflow sticky", uflow, 1);
    chk(red == 0, "R8 R7 idle after underflow", red, 0);
    rrst_n = 0;
    @(negedge rclk);
    chk(uflow == 0, "R1 R8 reader reset clears flag", uflow, 0);

    // release both, let the buffer fill
    @(negedge wclk); wrst_n = 1;
    @(negedge rclk); rrst_n = 1;
    repeat (100) step(1'b0);

    // random gaps with request
    for (int i = 0; i < 3000; i++) step(($urandom % 4) != 0);
    // sustained burst
    for (int i = 0; i < 1500; i++) step(1'b1);
    for (int i = 0; i < 500; i++) step(($urandom % 8) == 0);
    step(1'b0);
    step(1'b0);
    chk(pix_n > 2 * HT * VT, "R3 R4 frames covered", pix_n, 2 * HT * VT);
    summary();
  end
endmodule